// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Zero Suppression

This block turns one binary-coded decimal digit into seven segment drives for a common-anode display. The drives are active low, so a 0 lights a segment. Three control inputs, all active low, change what the display shows:

- a forced-blank input turns the digit dark;
- a lamp-test input lights every segment;
- a ripple-blank input hides the digit only when it is zero.

A ripple-blank output lets several decoders be chained so that leading zeros of a multi-digit number stay dark. In such a chain, each decoder's ripple output feeds the ripple input of the next, less significant, digit. The most significant digit has its ripple input tied low. The least significant digit has its ripple input tied high, so a value of zero still shows a single 0.

The block is purely combinational. Its inner structure has three parts:

- a glyph lookup;
- a priority resolver that picks one display mode out of five (SHOW, LAMP, FORCE_OFF, ZERO_OFF, BAD_CODE);
- a drive stage that maps the chosen mode to the segment lines and the ripple output.

Mode selection, from highest to lowest priority:

- forced-blank low picks FORCE_OFF;
- otherwise lamp-test low picks LAMP;
- otherwise a code above 9 picks BAD_CODE;
- otherwise ripple-blank low with a zero code picks ZERO_OFF;
- otherwise the mode is SHOW.

Top module: `bcd7_blank_decoder`

## Requirements
- R1: With all three controls high, codes 0 to 9 drive `seg_n_o` (bit 0 = segment a ... bit 6 = segment g, 0 = lit) to the active-low values 0 → 7'h40, 1 → 7'h79, 2 → 7'h24, 3 → 7'h30, 4 → 7'h19, 5 → 7'h12, 6 → 7'h02, 7 → 7'h78, 8 → 7'h00, 9 → 7'h10, and `ripple_out_n_o` is 1.
- R2: Codes 10 to 15 drive `seg_n_o` to 7'h7F (all dark) with `ripple_out_n_o` = 1, unless forced-blank or lamp-test is active.
- R3: With `blank_n_i` high and `lamp_test_n_i` low, `seg_n_o` is 7'h00 for any code, and `ripple_out_n_o` is 1.
- R4: With `blank_n_i` low, `seg_n_o` is 7'h7F and `ripple_out_n_o` is 1, whatever the code, lamp-test or ripple input is.
- R5: With `ripple_in_n_i` low, the other controls high and code 0, `seg_n_o` is 7'h7F and `ripple_out_n_o` is 0. `ripple_out_n_o` is 0 in no other case.
- R6: With `ripple_in_n_i` low and a nonzero code from 1 to 9, the digit decodes as in R1 and `ripple_out_n_o` is 1.
- R7: Lamp-test wins over ripple blanking: lamp-test low, ripple input low and code 0 give 7'h00 with `ripple_out_n_o` = 1.
- R8: In a chain whose most significant ripple input is tied low and whose least significant ripple input is tied high, the leading zeros are dark, zeros after the first nonzero digit are shown, and an all-zero value shows one 0 in the last digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit_i | input | 4 | BCD code to display |
| lamp_test_n_i | input | 1 | Active-low lamp test, lights all segments |
| blank_n_i | input | 1 | Active-low forced blank, highest priority |
| ripple_in_n_i | input | 1 | Active-low ripple-blank input, hides a zero |
| seg_n_o | output | 7 | Active-low segment drives, bit 0 = a to bit 6 = g |
| ripple_out_n_o | output | 1 | Active-low ripple-blank output, low only while a zero is hidden |

## Verification
The hardest case to reach is the cascade, where one digit's dark zero depends on every more significant digit also being a hidden zero. A single decoder cannot show this from its own ports. The bench therefore builds a four-digit chain and feeds it these values:

- values with leading zeros;
- values with inner zeros behind a nonzero digit;
- an all-zero value.

It checks that the dark region stops at the first nonzero digit, and that the last digit still shows 0. Separate table entries stack controls against each other, so that every priority order is tested at a single decoder.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;

    localparam int CODE_W = 4;
    localparam int SEG_W  = 7;
    localparam int MAX_DIGIT = 9;

    typedef enum logic [2:0] {
        MODE_SHOW,
        MODE_LAMP,
        MODE_FORCE_OFF,
        MODE_ZERO_OFF,
        MODE_BAD_CODE
    } disp_mode_e;

    // Active-high glyph, bit 0 = segment a ... bit 6 = segment g
    function automatic logic [SEG_W-1:0] glyph_of(input logic [CODE_W-1:0] code);
        logic [SEG_W-1:0] g;
        unique case (code)
            4'd0:    g = 7'b0111111;
            4'd1:    g = 7'b0000110;
            4'd2:    g = 7'b1011011;
            4'd3:    g = 7'b1001111;
            4'd4:    g = 7'b1100110;
            4'd5:    g = 7'b1101101;
            4'd6:    g = 7'b1111101;
            4'd7:    g = 7'b0000111;
            4'd8:    g = 7'b1111111;
            4'd9:    g = 7'b1101111;
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/bcd7_glyph.sv
module bcd7_glyph
    import bcd7_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_W-1:0]  lit_o,
    output logic              valid_o,
    output logic              zero_o
);

    always_comb begin
        valid_o = (code_i <= CODE_W'(MAX_DIGIT));
        zero_o  = (code_i == '0);
        lit_o   = glyph_of(code_i);
    end

    // R2: codes beyond nine produce no lit segment pattern
    always_comb begin
        if (!valid_o) begin
            p_bad_code_dark_r2: assert (lit_o == '0)
                else $error("glyph lit for out-of-range code");
        end
    end

endmodule

// File: rtl/bcd7_mode_sel.sv
module bcd7_mode_sel
    import bcd7_pkg::*;
(
    input  logic       force_off_n_i,
    input  logic       lamp_n_i,
    input  logic       ripple_in_n_i,
    input  logic       code_valid_i,
    input  logic       code_zero_i,
    output disp_mode_e mode_o
);

    always_comb begin
        if (!force_off_n_i)
            mode_o = MODE_FORCE_OFF;
        else if (!lamp_n_i)
            mode_o = MODE_LAMP;
        else if (!code_valid_i)
            mode_o = MODE_BAD_CODE;
        else if (!ripple_in_n_i && code_zero_i)
            mode_o = MODE_ZERO_OFF;
        else
            mode_o = MODE_SHOW;
    end

    // R4: forced blank wins over every other control
    always_comb begin
        if (!force_off_n_i) begin
            p_force_wins_r4: assert (mode_o == MODE_FORCE_OFF)
                else $error("forced blank not selected");
        end
    end

    // R7: lamp test outranks ripple blanking
    always_comb begin
        if (force_off_n_i && !lamp_n_i) begin
            p_lamp_over_ripple_r7: assert (mode_o == MODE_LAMP)
                else $error("lamp test not selected");
        end
    end

endmodule

// File: rtl/bcd7_drive.sv
module bcd7_drive
    import bcd7_pkg::*;
(
    input  disp_mode_e       mode_i,
    input  logic [SEG_W-1:0] lit_i,
    output logic [SEG_W-1:0] seg_n_o,
    output logic             ripple_out_n_o
);

    always_comb begin
        ripple_out_n_o = 1'b1;
        unique case (mode_i)
            MODE_SHOW:      seg_n_o = ~lit_i;
            MODE_LAMP:      seg_n_o = '0;
            MODE_FORCE_OFF: seg_n_o = '1;
            MODE_ZERO_OFF: begin
                seg_n_o        = '1;
                ripple_out_n_o = 1'b0;
            end
            MODE_BAD_CODE:  seg_n_o = '1;
            default:        seg_n_o = '1;
        endcase
    end

    // R5: a low ripple output always comes with a dark digit
    always_comb begin
        if (!ripple_out_n_o) begin
            p_ripple_dark_r5: assert (seg_n_o == '1)
                else $error("ripple output low with lit segments");
        end
    end

endmodule

// File: rtl/bcd7_blank_decoder.sv
module bcd7_blank_decoder
    import bcd7_pkg::*;
(
    input  logic [3:0] digit_i,
    input  logic       lamp_test_n_i,
    input  logic       blank_n_i,
    input  logic       ripple_in_n_i,
    output logic [6:0] seg_n_o,
    output logic       ripple_out_n_o
);

    logic [SEG_W-1:0] lit;
    logic             code_valid;
    logic             code_zero;
    disp_mode_e       mode;

    bcd7_glyph u_glyph (
        .code_i  (digit_i),
        .lit_o   (lit),
        .valid_o (code_valid),
        .zero_o  (code_zero)
    );

    bcd7_mode_sel u_mode (
        .force_off_n_i (blank_n_i),
        .lamp_n_i      (lamp_test_n_i),
        .ripple_in_n_i (ripple_in_n_i),
        .code_valid_i  (code_valid),
        .code_zero_i   (code_zero),
        .mode_o        (mode)
    );

    bcd7_drive u_drive (
        .mode_i         (mode),
        .lit_i          (lit),
        .seg_n_o        (seg_n_o),
        .ripple_out_n_o (ripple_out_n_o)
    );

    // R5: the ripple output only falls for a hidden zero
    always_comb begin
        if (!ripple_out_n_o) begin
            p_ripple_cause_r5: assert (digit_i == 4'd0 && !ripple_in_n_i
                                       && blank_n_i && lamp_test_n_i)
                else $error("ripple output low without a hidden zero");
        end
    end

    // R3: lamp test with blank released lights every segment
    always_comb begin
        if (blank_n_i && !lamp_test_n_i) begin
            p_lamp_all_lit_r3: assert (seg_n_o == '0 && ripple_out_n_o)
                else $error("lamp test left a segment dark");
        end
    end

endmodule

// File: tb/test_bcd7_blank_decoder.sv
module bcd7_chain4 (
    input  logic [15:0] value_i,
    output logic [27:0] seg_n_o
);
    logic [4:0] rip;
    assign rip[4] = 1'b0;
    for (genvar k = 3; k >= 0; k--) begin : g_dig
        logic rbi;
        assign rbi = (k == 0) ? 1'b1 : rip[k+1];
        bcd7_blank_decoder u_dec (
            .digit_i        (value_i[k*4 +: 4]),
            .lamp_test_n_i  (1'b1),
            .blank_n_i      (1'b1),
            .ripple_in_n_i  (rbi),
            .seg_n_o        (seg_n_o[k*7 +: 7]),
            .ripple_out_n_o (rip[k])
        );
    end
endmodule

module test_bcd7_blank_decoder;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [3:0] digit;
    logic       lt_n, bl_n, rbi_n;
    logic [6:0] seg_n;
    logic       rbo_n;
    logic [15:0] chain_val;
    logic [27:0] chain_seg;

    int n_checks = 0;
    int n_fail   = 0;

    bcd7_blank_decoder i_bcd7_blank_decoder (
        .digit_i        (digit),
        .lamp_test_n_i  (lt_n),
        .blank_n_i      (bl_n),
        .ripple_in_n_i  (rbi_n),
        .seg_n_o        (seg_n),
        .ripple_out_n_o (rbo_n)
    );

    bcd7_chain4 u_chain (.value_i(chain_val), .seg_n_o(chain_seg));

    // {code[15:12], lt_n[11], bl_n[10], rbi_n[9], seg_n[8:2], rbo_n[1], pad[0]}
    localparam int NV = 20;
    localparam logic [15:0] VEC [NV] = '{
        {4'd0, 3'b111, 7'h40, 1'b1, 1'b0},   // R1
        {4'd1, 3'b111, 7'h79, 1'b1, 1'b0},   // R1
        {4'd2, 3'b111, 7'h24, 1'b1, 1'b0},   // R1
        {4'd3, 3'b111, 7'h30, 1'b1, 1'b0},   // R1
        {4'd4, 3'b111, 7'h19, 1'b1, 1'b0},   // R1
        {4'd5, 3'b111, 7'h12, 1'b1, 1'b0},   // R1
        {4'd6, 3'b111, 7'h02, 1'b1, 1'b0},   // R1
        {4'd7, 3'b111, 7'h78, 1'b1, 1'b0},   // R1
        {4'd8, 3'b111, 7'h00, 1'b1, 1'b0},   // R1
        {4'd9, 3'b111, 7'h10, 1'b1, 1'b0},   // R1
        {4'd10, 3'b111, 7'h7F, 1'b1, 1'b0},  // R2
        {4'd15, 3'b110, 7'h7F, 1'b1, 1'b0},  // R2 with ripple low
        {4'd3, 3'b011, 7'h00, 1'b1, 1'b0},   // R3
        {4'd12, 3'b011, 7'h00, 1'b1, 1'b0},  // R3 bad code
        {4'd8, 3'b001, 7'h7F, 1'b1, 1'b0},   // R4 over lamp test
        {4'd0, 3'b100, 7'h7F, 1'b1, 1'b0},   // R4 over ripple
        {4'd0, 3'b110, 7'h7F, 1'b0, 1'b0},   // R5
        {4'd7, 3'b110, 7'h78, 1'b1, 1'b0},   // R6
        {4'd1, 3'b110, 7'h79, 1'b1, 1'b0},   // R6
        {4'd0, 3'b010, 7'h00, 1'b1, 1'b0}    // R7
    };
    localparam int VTAG [NV] = '{1,1,1,1,1,1,1,1,1,1,2,2,3,3,4,4,5,6,6,7};

    task automatic check_single(input int tag, input logic [6:0] es, input logic er);
        n_checks++;
        if (seg_n !== es || rbo_n !== er) begin
            n_fail++;
            $display("FAIL R%0d: code=%0d seg_n=%h rbo_n=%b expected seg_n=%h rbo_n=%b",
                     tag, digit, seg_n, rbo_n, es, er);
        end
    endtask

    task automatic check_chain(input logic [15:0] v, input logic [27:0] exp_seg);
        @(posedge clk);
        chain_val = v;
        @(negedge clk);
        n_checks++;
        if (chain_seg !== exp_seg) begin
            n_fail++;
            $display("FAIL R8: value=%h segs=%h expected %h", v, chain_seg, exp_seg);
        end
    endtask

    bit done = 1'b0;

    initial begin
        digit = 4'd0; lt_n = 1'b1; bl_n = 1'b0; rbi_n = 1'b1; chain_val = '0;
        // Initial state with blank held: dark (R4)
        @(negedge clk);
        check_single(4, 7'h7F, 1'b1);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            digit = VEC[i][15:12];
            lt_n  = VEC[i][11];
            bl_n  = VEC[i][10];
            rbi_n = VEC[i][9];
            @(negedge clk);
            check_single(VTAG[i], VEC[i][8:2], VEC[i][1]);
        end

        // R2: every out-of-range code dark under ripple and normal input
        for (int c = 10; c < 16; c++) begin
            @(posedge clk);
            digit = 4'(c); lt_n = 1'b1; bl_n = 1'b1; rbi_n = 1'(c % 2);
            @(negedge clk);
            check_single(2, 7'h7F, 1'b1);
        end

        // R4: forced blank holds for every code with lamp test low
        for (int c = 0; c < 16; c++) begin
            @(posedge clk);
            digit = 4'(c); lt_n = 1'b0; bl_n = 1'b0; rbi_n = 1'b0;
            @(negedge clk);
            check_single(4, 7'h7F, 1'b1);
        end

        // R8: cascade of four digits, digit 3 most significant
        check_chain(16'h0042, {7'h7F, 7'h7F, 7'h19, 7'h24});
        check_chain(16'h0000, {7'h7F, 7'h7F, 7'h7F, 7'h40});
        check_chain(16'h1005, {7'h79, 7'h40, 7'h40, 7'h12});
        check_chain(16'h0300, {7'h7F, 7'h30, 7'h40, 7'h40});
        check_chain(16'h9000, {7'h10, 7'h40, 7'h40, 7'h40});

        done = 1'b1;
    end

    initial begin : watchdog
        for (int t = 0; t < 5000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule